// File: doc/BRIEF.md
# Partial-Access 64-bit Register File

This block holds the general-purpose integer registers of a 64-bit core whose instructions can name a register at several operand widths. Every register is 64 bits wide. An access may use the whole register, its low 32 bits, its low 16 bits, its low byte, or, for the first four registers only, bits 15:8. Two combinational read ports and one write port on the clock edge each take a register selector, a size code and a prefix flag. Each port decodes these into a physical register and a lane within it.

A write merges its operand into the stored value according to the lane. A 32-bit write is the one exception: it clears the upper half. Reads return the selected lane right-aligned and zero-extended.

The block also checks the operand forms of one operation taken as a whole. A combination that the encoding forbids raises `err` in the same cycle. When `err` is high, the write is dropped and both read results are forced to zero. The register count defaults to 16, and a parameter can raise it to 32.

Top module: `partial_regfile`

## Requirements
- R1: After a synchronous active-low reset, every register holds zero.
- R2: A write with size code 3 (64 bits) replaces all 64 bits of the register. A 64-bit read returns the whole register.
- R3: A write with size code 2 (32 bits) stores `wr_data[31:0]` in bits 31:0 and clears bits 63:32.
- R4: A write with size code 1 (16 bits) changes only bits 15:0. A low-byte write changes only bits 7:0. The operand is taken from the low bits of `wr_data`.
- R5: For size code 0 (byte) with the prefix flag clear, selectors 0–3 name the low bytes of registers 0–3. Selectors 4–7 name bits 15:8 of registers 0, 1, 2 and 3, in that order. A high-byte write takes its operand from `wr_data[7:0]`.
- R6: For size code 0 with the prefix flag set, selector n names bits 7:0 of register n, for every n, including 4–7 and 8 and above.
- R7: An enabled port whose prefix flag is clear and whose selector is 8 or above is illegal, whatever its size.
- R8: An operation is illegal if any enabled port has its prefix flag set while any enabled port names a high byte. A port that is not enabled takes no part in either check.
- R9: An illegal operation drives `err` high in the same cycle, leaves every register unchanged, and forces both read outputs to zero.
- R10: A read returns its lane right-aligned and zero-extended to 64 bits. A high-byte read returns bits 15:8 in bits 7:0. A disabled read port outputs zero.
- R11: Reads are combinational. In the cycle of a write they return the value held before it. A legal write takes effect on the rising clock edge when `wr_en` is high, and no other register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd0_en | input | 1 | Read port 0 takes part in the operation |
| rd0_idx | input | IDX_W | Read port 0 register selector |
| rd0_size | input | 2 | Read port 0 size code (0 byte, 1 16-bit, 2 32-bit, 3 64-bit) |
| rd0_pfx | input | 1 | Read port 0 prefix flag |
| rd0_data | output | 64 | Read port 0 result, zero-extended |
| rd1_en | input | 1 | Read port 1 takes part in the operation |
| rd1_idx | input | IDX_W | Read port 1 register selector |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_pfx | input | 1 | Read port 1 prefix flag |
| rd1_data | output | 64 | Read port 1 result, zero-extended |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Write register selector |
| wr_size | input | 2 | Write size code |
| wr_pfx | input | 1 | Write prefix flag |
| wr_data | input | 64 | Write operand, right-aligned |
| err | output | 1 | Illegal operand combination in this cycle |

## Verification
The fault that matters most is a stored register that differs from what the merge rules predict. For example, upper bits might survive a 32-bit write, or a high-byte write might land in the low byte. Such a fault stays hidden until the register is read. The bench therefore reads the full register on the cycle after every write, so a bad merge or a misrouted selector shows at the port one cycle after the edge that caused it. A wrong legality decision is different: it shows on `err` and on the zeroed read data in the same cycle, because both are combinational.

// File: rtl/rf_pkg.sv
// Package for the partial-access register file.
// Defines the size codes seen at the ports and the lane codes used inside.
// Assumes operands are never wider than 64 bits.
package rf_pkg;

    localparam int unsigned XLEN = 64;

    // Size codes as they appear on the ports.
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_QWORD = 2'd3
    } opsize_e;

    // The part of a register that one access touches.
    typedef enum logic [2:0] {
        LN_LO8  = 3'd0,
        LN_HI8  = 3'd1,
        LN_W16  = 3'd2,
        LN_D32  = 3'd3,
        LN_Q64  = 3'd4
    } lane_e;

endpackage

// File: rtl/rf_operand_decode.sv
// Turns one port's selector, size and prefix flag into a physical register,
// a lane and two flags: the port names a high byte, or the port is illegal
// on its own. A disabled port raises neither flag.
// Assumes IDX_W >= 4, so the "selector of 8 or above" test is meaningful.
module rf_operand_decode
    import rf_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    input  logic             pfx,
    output logic [IDX_W-1:0] phys,
    output lane_e            lane,
    output logic             uses_hi,
    output logic             bad
);

    logic beyond_legacy;

    // True when the selector needs the prefix to be reachable.
    always_comb beyond_legacy = (idx[IDX_W-1:3] != '0);

    // Map the selector and size onto a lane and a physical register.
    always_comb begin
        phys    = idx;
        lane    = LN_Q64;
        uses_hi = 1'b0;
        unique case (opsize_e'(size))
            SZ_BYTE: begin
                if (!pfx && !beyond_legacy && idx[2]) begin
                    lane    = LN_HI8;
                    phys[2] = 1'b0;
                    uses_hi = 1'b1;
                end else begin
                    lane = LN_LO8;
                end
            end
            SZ_WORD:  lane = LN_W16;
            SZ_DWORD: lane = LN_D32;
            default:  lane = LN_Q64;
        endcase
        if (!en) begin
            uses_hi = 1'b0;
        end
    end

    // A port without the prefix cannot reach selectors 8 and above.
    always_comb bad = en && !pfx && beyond_legacy;

endmodule

// File: rtl/rf_write_merge.sv
// Builds the new 64-bit register value from the old value and a right-aligned
// operand, following the lane. A 32-bit lane clears the upper half; the other
// narrow lanes keep every bit outside the lane.
module rf_write_merge
    import rf_pkg::*;
(
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] operand,
    input  lane_e           lane,
    output logic [XLEN-1:0] merged
);

    // Splice the operand into the old value.
    always_comb begin
        unique case (lane)
            LN_LO8:  merged = {old_val[XLEN-1:8], operand[7:0]};
            LN_HI8:  merged = {old_val[XLEN-1:16], operand[7:0], old_val[7:0]};
            LN_W16:  merged = {old_val[XLEN-1:16], operand[15:0]};
            LN_D32:  merged = {{(XLEN-32){1'b0}}, operand[31:0]};
            default: merged = operand;
        endcase
    end

endmodule

// File: rtl/rf_read_align.sv
// Extracts one lane of a stored register, right-aligns it and zero-extends it
// to 64 bits. A high byte is shifted down into bits 7:0.
module rf_read_align
    import rf_pkg::*;
(
    input  logic [XLEN-1:0] stored,
    input  lane_e           lane,
    output logic [XLEN-1:0] aligned
);

    // Select the lane and pad it with zeros.
    always_comb begin
        unique case (lane)
            LN_LO8:  aligned = {{(XLEN-8){1'b0}},  stored[7:0]};
            LN_HI8:  aligned = {{(XLEN-8){1'b0}},  stored[15:8]};
            LN_W16:  aligned = {{(XLEN-16){1'b0}}, stored[15:0]};
            LN_D32:  aligned = {{(XLEN-32){1'b0}}, stored[31:0]};
            default: aligned = stored;
        endcase
    end

endmodule

// File: rtl/partial_regfile.sv
// Register file with partial-width access: two combinational read ports and
// one write port on the clock edge. Each port is decoded on its own. The
// legality of the operation is judged across all enabled ports. An illegal
// operation drops the write and zeroes both reads.
// Assumes NUM_REGS is 16 or 32.
module partial_regfile
    import rf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned NRD     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd0_en,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [1:0]       rd0_size,
    input  logic             rd0_pfx,
    output logic [XLEN-1:0]  rd0_data,
    input  logic             rd1_en,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [1:0]       rd1_size,
    input  logic             rd1_pfx,
    output logic [XLEN-1:0]  rd1_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_size,
    input  logic             wr_pfx,
    input  logic [XLEN-1:0]  wr_data,
    output logic             err
);

    logic [NUM_REGS-1:0][XLEN-1:0] regs_q;

    logic [NRD-1:0]            rp_en;
    logic [NRD-1:0][IDX_W-1:0] rp_idx;
    logic [NRD-1:0][1:0]       rp_size;
    logic [NRD-1:0]            rp_pfx;
    logic [NRD-1:0][IDX_W-1:0] rp_phys;
    lane_e                     rp_lane [NRD];
    logic [NRD-1:0]            rp_hi;
    logic [NRD-1:0]            rp_bad;
    logic [NRD-1:0][XLEN-1:0]  rp_val;

    logic [IDX_W-1:0] wp_phys;
    lane_e            wp_lane;
    logic             wp_hi;
    logic             wp_bad;
    logic [XLEN-1:0]  wp_merged;
    logic             any_pfx;
    logic             any_hi;
    logic             wr_fire;

    // Gather the read-port inputs into arrays so the ports can share one generate loop.
    always_comb begin
        rp_en   = {rd1_en,   rd0_en};
        rp_idx  = {rd1_idx,  rd0_idx};
        rp_size = {rd1_size, rd0_size};
        rp_pfx  = {rd1_pfx,  rd0_pfx};
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rf_operand_decode #(.IDX_W(IDX_W)) u_dec (
            .en      (rp_en[p]),
            .idx     (rp_idx[p]),
            .size    (rp_size[p]),
            .pfx     (rp_pfx[p]),
            .phys    (rp_phys[p]),
            .lane    (rp_lane[p]),
            .uses_hi (rp_hi[p]),
            .bad     (rp_bad[p])
        );
        rf_read_align u_align (
            .stored  (regs_q[rp_phys[p]]),
            .lane    (rp_lane[p]),
            .aligned (rp_val[p])
        );
    end

    rf_operand_decode #(.IDX_W(IDX_W)) u_wdec (
        .en      (wr_en),
        .idx     (wr_idx),
        .size    (wr_size),
        .pfx     (wr_pfx),
        .phys    (wp_phys),
        .lane    (wp_lane),
        .uses_hi (wp_hi),
        .bad     (wp_bad)
    );

    rf_write_merge u_merge (
        .old_val (regs_q[wp_phys]),
        .operand (wr_data),
        .lane    (wp_lane),
        .merged  (wp_merged)
    );

    // Judge legality across the enabled ports: no prefix mixed with a high byte.
    always_comb begin
        any_pfx = (rd0_en && rd0_pfx) || (rd1_en && rd1_pfx) || (wr_en && wr_pfx);
        any_hi  = (|rp_hi) || wp_hi;
        err     = (|rp_bad) || wp_bad || (any_pfx && any_hi);
        wr_fire = wr_en && !err;
    end

    // Drive the read results; an illegal or disabled read returns zero.
    always_comb begin
        rd0_data = (rd0_en && !err) ? rp_val[0] : '0;
        rd1_data = (rd1_en && !err) ? rp_val[1] : '0;
    end

    // Storage: clear on reset, otherwise take the merged value on a legal write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_fire) begin
            regs_q[wp_phys] <= wp_merged;
        end
    end

endmodule

// File: rtl/rf_checker.sv
// Property checker for partial_regfile, attached by bind. It keeps a copy of
// the last cycle's write request and the register contents of that cycle, and
// compares the stored state after each edge with the rules on the ports.
module rf_checker
    import rf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          rd0_en,
    input logic [1:0]                    rd0_size,
    input logic                          rd0_pfx,
    input logic [XLEN-1:0]               rd0_data,
    input logic [XLEN-1:0]               rd1_data,
    input logic                          wr_en,
    input logic [IDX_W-1:0]              wr_idx,
    input logic [1:0]                    wr_size,
    input logic                          wr_pfx,
    input logic [XLEN-1:0]               wr_data,
    input logic                          err,
    input logic [NUM_REGS-1:0][XLEN-1:0] regs_q
);

    logic                          cap_valid;
    logic                          cap_we;
    logic                          cap_blocked;
    logic [IDX_W-1:0]              cap_idx;
    logic [1:0]                    cap_size;
    logic [XLEN-1:0]               cap_data;
    logic [NUM_REGS-1:0][XLEN-1:0] cap_regs;

    // Record the request of each cycle and the state it acted on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid   <= 1'b0;
            cap_we      <= 1'b0;
            cap_blocked <= 1'b0;
            cap_idx     <= '0;
            cap_size    <= '0;
            cap_data    <= '0;
            cap_regs    <= '0;
        end else begin
            cap_valid   <= 1'b1;
            cap_we      <= wr_en && !err;
            cap_blocked <= wr_en && err;
            cap_idx     <= wr_idx;
            cap_size    <= wr_size;
            cap_data    <= wr_data;
            cap_regs    <= regs_q;
        end
    end

    p_qword_replace_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_we && cap_size == 2'd3) |-> (regs_q[cap_idx] == cap_data));

    p_dword_clears_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_we && cap_size == 2'd2)
        |-> (regs_q[cap_idx] == {32'h0, cap_data[31:0]}));

    p_word_keeps_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_we && cap_size == 2'd1)
        |-> (regs_q[cap_idx] == {cap_regs[cap_idx][XLEN-1:16], cap_data[15:0]}));

    p_mix_raises_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_en && rd0_pfx && wr_en && !wr_pfx && wr_size == 2'd0
         && wr_idx >= IDX_W'(4) && wr_idx <= IDX_W'(7)) |-> err);

    p_err_freezes_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_blocked) |-> (regs_q == cap_regs));

    p_err_zero_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rd0_data == '0 && rd1_data == '0));

    p_byte_read_narrow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_en && rd0_size == 2'd0) |-> (rd0_data[XLEN-1:8] == '0));

    p_idle_keeps_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !cap_we) |-> (regs_q == cap_regs));

endmodule

bind partial_regfile rf_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd0_en   (rd0_en),
    .rd0_size (rd0_size),
    .rd0_pfx  (rd0_pfx),
    .rd0_data (rd0_data),
    .rd1_data (rd1_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_size  (wr_size),
    .wr_pfx   (wr_pfx),
    .wr_data  (wr_data),
    .err      (err),
    .regs_q   (regs_q)
);

// File: tb/tb_partial_regfile.sv
// Self-checking bench: a sweep over every selector, size and prefix value on
// a 16-register instance, with a bench-side model of the merge rules.
module tb_partial_regfile;

    localparam int NR = 16;
    localparam int IW = 4;

    logic          clk;
    logic          rst_n;
    logic          rd0_en, rd0_pfx, rd1_en, rd1_pfx, wr_en, wr_pfx;
    logic [IW-1:0] rd0_idx, rd1_idx, wr_idx;
    logic [1:0]    rd0_size, rd1_size, wr_size;
    logic [63:0]   rd0_data, rd1_data, wr_data;
    logic          err;

    int          n_chk;
    int          n_fail;
    logic [63:0] mdl [NR];

    partial_regfile #(.NUM_REGS(NR)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_en(rd0_en), .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_pfx(rd0_pfx), .rd0_data(rd0_data),
        .rd1_en(rd1_en), .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_pfx(rd1_pfx), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_pfx(wr_pfx), .wr_data(wr_data),
        .err(err)
    );

    // 50 MHz clock: 20 time-unit period.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [63:0] pat(input int a);
        return 64'hA5C3_0F96_1E2D_3C4B ^ (64'(a + 1) * 64'h9E37_79B9_7F4A_7C15);
    endfunction

    // kind: 0 low byte, 1 high byte, 2 16-bit, 3 32-bit, 4 64-bit
    task automatic mdecode(input int idx, input int sz, input int pfx,
                           output int phys, output int kind, output bit hi, output bit bad);
        phys = idx;
        hi   = 1'b0;
        bad  = (pfx == 0) && (idx >= 8);
        case (sz)
            0: if (pfx == 0 && idx >= 4 && idx <= 7) begin kind = 1; phys = idx - 4; hi = 1'b1; end
               else kind = 0;
            1: kind = 2;
            2: kind = 3;
            default: kind = 4;
        endcase
    endtask

    function automatic logic [63:0] mread(input logic [63:0] v, input int kind);
        case (kind)
            0: return v & 64'hFF;
            1: return (v >> 8) & 64'hFF;
            2: return v & 64'hFFFF;
            3: return v & 64'hFFFF_FFFF;
            default: return v;
        endcase
    endfunction

    function automatic logic [63:0] mwrite(input logic [63:0] o, input logic [63:0] d, input int kind);
        case (kind)
            0: return (o & ~64'hFF)   | (d & 64'hFF);
            1: return (o & ~64'hFF00) | ((d & 64'hFF) << 8);
            2: return (o & ~64'hFFFF) | (d & 64'hFFFF);
            3: return d & 64'hFFFF_FFFF;
            default: return d;
        endcase
    endfunction

    function automatic string kind_tag(input int kind, input int pfx);
        case (kind)
            0: return (pfx != 0) ? "R6" : "R4";
            1: return "R5";
            2: return "R4";
            3: return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        rd0_en = 0; rd0_idx = '0; rd0_size = 2'd3; rd0_pfx = 0;
        rd1_en = 0; rd1_idx = '0; rd1_size = 2'd3; rd1_pfx = 0;
        wr_en  = 0; wr_idx  = '0; wr_size  = 2'd3; wr_pfx  = 0; wr_data = '0;
    endtask

    // Read a whole register through port 1 and compare it with the model.
    task automatic read_full(input int r, input string tag);
        @(negedge clk);
        idle();
        rd1_en = 1; rd1_idx = IW'(r); rd1_size = 2'd3; rd1_pfx = 1;
        #2;
        chk(tag, rd1_data, mdl[r]);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int  phys, kind;
        bit  hi, bad;
        logic [63:0] d;
        n_chk = 0; n_fail = 0;
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: every register reads zero after reset.
        for (int r = 0; r < NR; r++) begin
            mdl[r] = '0;
            read_full(r, "R1");
            chk("R1", 64'(err), 64'd0);
        end

        // R2: preload every register with a full 64-bit value.
        for (int r = 0; r < NR; r++) begin
            @(negedge clk);
            idle();
            wr_en = 1; wr_idx = IW'(r); wr_size = 2'd3; wr_pfx = 1; wr_data = pat(100 + r);
            @(posedge clk);
            mdl[r] = pat(100 + r);
            read_full(r, "R2");
        end

        // Sweep writes over every selector, size and prefix value; read the old value in the same cycle.
        for (int i = 0; i < NR; i++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int p = 0; p < 2; p++) begin
                    mdecode(i, sz, p, phys, kind, hi, bad);
                    d = pat(i * 8 + sz * 2 + p);
                    @(negedge clk);
                    idle();
                    wr_en = 1; wr_idx = IW'(i); wr_size = 2'(sz); wr_pfx = p[0]; wr_data = d;
                    rd0_en = 1; rd0_idx = IW'(i); rd0_size = 2'(sz); rd0_pfx = p[0];
                    #2;
                    chk("R7", 64'(err), 64'(bad));
                    chk("R11", rd0_data, bad ? 64'd0 : mread(mdl[phys], kind));
                    @(posedge clk);
                    if (!bad) mdl[phys] = mwrite(mdl[phys], d, kind);
                    read_full(phys, bad ? "R9" : kind_tag(kind, p));
                end
            end
        end

        // R8: high-byte write mixed with a prefixed read is refused.
        @(negedge clk);
        idle();
        wr_en = 1; wr_idx = 4'd4; wr_size = 2'd0; wr_pfx = 0; wr_data = 64'h5A;
        rd1_en = 1; rd1_idx = 4'd5; rd1_size = 2'd3; rd1_pfx = 1;
        #2;
        chk("R8", 64'(err), 64'd1);
        chk("R9", rd1_data, 64'd0);
        @(posedge clk);
        read_full(0, "R9");

        // R8: prefixed low-byte write mixed with a high-byte read is refused.
        @(negedge clk);
        idle();
        wr_en = 1; wr_idx = 4'd4; wr_size = 2'd0; wr_pfx = 1; wr_data = 64'hC3;
        rd0_en = 1; rd0_idx = 4'd6; rd0_size = 2'd0; rd0_pfx = 0;
        #2;
        chk("R8", 64'(err), 64'd1);
        chk("R9", rd0_data, 64'd0);
        @(posedge clk);
        read_full(4, "R9");

        // R8: the same high-byte write with the prefixed port disabled goes through.
        @(negedge clk);
        idle();
        wr_en = 1; wr_idx = 4'd7; wr_size = 2'd0; wr_pfx = 0; wr_data = 64'h1E7;
        rd1_en = 0; rd1_idx = 4'd12; rd1_size = 2'd3; rd1_pfx = 1;
        #2;
        chk("R8", 64'(err), 64'd0);
        @(posedge clk);
        mdl[3] = mwrite(mdl[3], 64'h1E7, 1);
        read_full(3, "R5");

        // R7: a disabled port with an unreachable selector raises nothing.
        @(negedge clk);
        idle();
        rd0_en = 0; rd0_idx = 4'd12; rd0_pfx = 0;
        #2;
        chk("R7", 64'(err), 64'd0);
        chk("R10", rd0_data, 64'd0);

        // R10: read sweep over every form with no write.
        for (int i = 0; i < NR; i++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int p = 0; p < 2; p++) begin
                    mdecode(i, sz, p, phys, kind, hi, bad);
                    @(negedge clk);
                    idle();
                    rd0_en = 1; rd0_idx = IW'(i); rd0_size = 2'(sz); rd0_pfx = p[0];
                    #2;
                    chk("R10", rd0_data, bad ? 64'd0 : mread(mdl[phys], kind));
                    chk("R7", 64'(err), 64'(bad));
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule